// File: doc/BRIEF.md
# Dual-Mode Interrupt Status Aggregator

This block takes a vector of internal event sources and produces one active-high interrupt line. A parameter fixes each source as level-type or edge-type. A level-type source reports a live condition. Its raw bit follows that condition, and its status bit records every change in either direction. An edge-type source reports short pulses. Its raw bit catches a pulse and holds it, and its status bit records only the moment the raw bit goes from 0 to 1.

Every status bit is sticky and stays at 1 until software writes a 1 to the matching clear bit. A per-source enable mask decides which status bits reach the interrupt line. The interrupt is the registered OR of the enabled status bits. Software reaches raw, status, clear and enable through a plain address/data register port with a write strobe and a combinational read path.

Top module: `irq_status_agg`

## Requirements
- R1: A level-type raw bit shows the condition input as sampled at the previous clock edge. It is never latched, and writing its clear bit leaves it unchanged.
- R2: An edge-type raw bit goes to 1 in the cycle after its input pulse is high. It then stays at 1, whatever the input does, until a 1 is written to that source's clear bit.
- R3: A level-type status bit becomes 1 one cycle after its raw bit changes value, whether the raw bit rises or falls.
- R4: An edge-type status bit becomes 1 one cycle after its raw bit rises. A fall of that raw bit never sets the status bit.
- R5: A status bit that is 1 keeps that value until a write of 1 reaches its clear bit. Writing 0 to a clear bit has no effect.
- R6: If a status-setting change and a clear of the same source take effect on the same clock edge, the status bit ends at 1.
- R7: For an edge-type source, one clear write returns both its raw bit and its status bit to 0 at the same edge.
- R8: The interrupt output is 1 exactly one cycle after some status bit and its enable bit are both 1. It is 0 one cycle after no enabled status bit remains. With all enables at 0, the interrupt stays 0.
- R9: Reset sets every raw, status and enable bit to 0 and holds the interrupt output at 0.
- R10: Register map, one bit per source at bit position equal to the source index: address 0 reads raw, address 1 reads status, address 2 is the write-one clear register and always reads 0, and address 3 is the enable mask, which is read/write. Writes to addresses 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | Event inputs: the condition for level-type sources, the pulse for edge-type sources |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr (combinational) |
| irq | output | 1 | Registered, active-high interrupt |

## Verification
A wrong sticky bit appears at address 1 one edge after the event that should or should not have set it. It reaches `irq` one edge later, but only when that source is enabled. A latch fault in an edge-type source shows at address 0 as a raw bit that drops without a clear, or one that survives a clear, and both are visible at the next read. A wrong transition detector looks different for each source type: a level-type source misses the falling change, and an edge-type source raises status when a clear makes its raw bit fall. Each of these is visible in the status read two edges after the stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      SEL_RAW    = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_CLEAR  = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;

   localparam int unsigned MIN_ADDR_W = 2;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter bit LEVEL_TYPE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic raw_o,
   output logic status_o
);

   logic raw_q;
   logic prev_q;
   logic status_q;
   logic set_evt;

   // previous sample of the raw bit, shared by both variants
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= raw_q;
   end

   generate
      if (LEVEL_TYPE) begin : g_level
         always_ff @(posedge clk) begin
            if (!rst_n) raw_q <= 1'b0;
            else        raw_q <= evt_i;
         end
         assign set_evt = raw_q ^ prev_q;

         assert_level_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q != prev_q) |=> status_q);
         assert_level_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (raw_q == $past(evt_i)));
      end else begin : g_edge
         always_ff @(posedge clk) begin
            if (!rst_n)     raw_q <= 1'b0;
            else if (evt_i) raw_q <= 1'b1;
            else if (clr_i) raw_q <= 1'b0;
         end
         assign set_evt = raw_q & ~prev_q;

         assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q && !clr_i) |=> raw_q);
         assert_edge_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q) |-> $past(raw_q && !prev_q));
         assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !evt_i) |=> !raw_q);
      end
   endgenerate

   // sticky status: a set event takes priority over a clear
   always_ff @(posedge clk) begin
      if (!rst_n)       status_q <= 1'b0;
      else if (set_evt) status_q <= 1'b1;
      else if (clr_i)   status_q <= 1'b0;
   end

   assign raw_o    = raw_q;
   assign status_o = status_q;

   assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_i) |=> status_q);

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic [NUM_SRC-1:0] raw_i,
   input  logic [NUM_SRC-1:0] status_i,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] enable_o,
   output logic [NUM_SRC-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(SEL_RAW);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(SEL_STATUS);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(SEL_CLEAR);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(SEL_ENABLE);

   logic [NUM_SRC-1:0] enable_q;
   logic               hit_clear;
   logic               hit_enable;

   assign hit_clear  = wr_en && (addr == A_CLEAR);
   assign hit_enable = wr_en && (addr == A_ENABLE);

   // clear bits exist only as a one-cycle strobe
   assign clr_o = hit_clear ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)          enable_q <= '0;
      else if (hit_enable) enable_q <= wdata;
   end
   assign enable_o = enable_q;

   always_comb begin
      case (addr)
         A_RAW:    rdata_o = raw_i;
         A_STATUS: rdata_o = status_i;
         A_ENABLE: rdata_o = enable_q;
         default:  rdata_o = '0;
      endcase
   end

   assert_clear_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> wr_en);
   assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_enable |=> $stable(enable_q));

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] enable_i,
   output logic               irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_i & enable_i);
   end
   assign irq_o = irq_q;

   assert_no_enable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i == '0) |=> !irq_q);

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned          NUM_SRC   = 8,
   parameter logic [NUM_SRC-1:0]   LEVEL_SRC = 8'h0F,
   parameter int unsigned          ADDR_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [NUM_SRC-1:0] reg_wdata,
   output logic [NUM_SRC-1:0] reg_rdata,
   output logic               irq
);

   initial begin
      assert_param_src_R10: assert (NUM_SRC >= 1);
      assert_param_addr_R10: assert (ADDR_W >= MIN_ADDR_W);
   end

   logic [NUM_SRC-1:0] raw_vec;
   logic [NUM_SRC-1:0] status_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] enable_vec;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_src_cell #(
            .LEVEL_TYPE (LEVEL_SRC[i])
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (src_evt[i]),
            .clr_i    (clr_vec[i]),
            .raw_o    (raw_vec[i]),
            .status_o (status_vec[i])
         );
      end
   endgenerate

   irq_regfile #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .raw_i    (raw_vec),
      .status_i (status_vec),
      .clr_o    (clr_vec),
      .enable_o (enable_vec),
      .rdata_o  (reg_rdata)
   );

   irq_out_stage #(
      .NUM_SRC (NUM_SRC)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_vec),
      .enable_i (enable_vec),
      .irq_o    (irq)
   );

   assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_vec & enable_vec) != '0) |=> irq);
   assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_vec & enable_vec) == '0) |=> !irq);

endmodule

// File: tb/irq_status_agg_test.sv
module irq_status_agg_test;

   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_evt = '0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [NS-1:0] reg_wdata = '0;
   logic [NS-1:0] reg_rdata;
   logic          irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_status_agg uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_evt   (src_evt),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [NS-1:0] got, input logic [NS-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [NS-1:0] v;
      rd(2'd0, v); check("R9 raw after reset", v, 8'h00);
      rd(2'd1, v); check("R9 status after reset", v, 8'h00);
      rd(2'd3, v); check("R9 enable after reset", v, 8'h00);
      rd(2'd2, v); check("R10 clear reads zero", v, 8'h00);
      check("R9 irq after reset", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_level;
      logic [NS-1:0] v;
      src_evt[0] = 1'b1;
      tick(1);
      rd(2'd0, v); check("R1 level raw follows", v, 8'h01);
      tick(1);
      rd(2'd1, v); check("R3 level rise sets status", v, 8'h01);
      check("R8 irq masked off", {7'd0, irq}, 8'h00);
      wr(2'd2, 8'h01);
      rd(2'd1, v); check("R5 clear drops status", v, 8'h00);
      rd(2'd0, v); check("R1 clear leaves level raw", v, 8'h01);
      src_evt[0] = 1'b0;
      tick(2);
      rd(2'd0, v); check("R1 level raw falls", v, 8'h00);
      rd(2'd1, v); check("R3 level fall sets status", v, 8'h01);
      wr(2'd2, 8'h00);
      tick(3);
      rd(2'd1, v); check("R5 write zero and hold", v, 8'h01);
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h00);
      rd(2'd1, v); check("R10 status not writable", v, 8'h01);
      rd(2'd0, v); check("R10 raw not writable", v, 8'h00);
      wr(2'd2, 8'h01);
      rd(2'd1, v); check("R5 final clear", v, 8'h00);
   endtask

   task automatic t_edge;
      logic [NS-1:0] v;
      src_evt[4] = 1'b1;
      tick(1);
      src_evt[4] = 1'b0;
      rd(2'd0, v); check("R2 edge raw catches pulse", v, 8'h10);
      tick(1);
      rd(2'd1, v); check("R4 edge rise sets status", v, 8'h10);
      tick(3);
      rd(2'd0, v); check("R2 edge raw held", v, 8'h10);
      wr(2'd2, 8'h10);
      rd(2'd0, v); check("R7 clear drops edge raw", v, 8'h00);
      rd(2'd1, v); check("R7 clear drops edge status", v, 8'h00);
      tick(2);
      rd(2'd1, v); check("R4 raw fall does not set", v, 8'h00);
   endtask

   task automatic t_set_wins;
      logic [NS-1:0] v;
      src_evt[1] = 1'b1;
      tick(1);
      wr(2'd2, 8'h02);
      rd(2'd1, v); check("R6 set beats clear", v, 8'h02);
      wr(2'd2, 8'h02);
      rd(2'd1, v); check("R6 later clear works", v, 8'h00);
   endtask

   task automatic t_mask;
      logic [NS-1:0] v;
      src_evt[2] = 1'b1;
      src_evt[6] = 1'b1;
      tick(1);
      src_evt[6] = 1'b0;
      tick(2);
      rd(2'd1, v); check("R8 two status bits", v, 8'h44);
      check("R8 irq low with enables off", {7'd0, irq}, 8'h00);
      wr(2'd3, 8'h40);
      rd(2'd3, v); check("R10 enable readback", v, 8'h40);
      tick(1);
      check("R8 irq from edge source", {7'd0, irq}, 8'h01);
      wr(2'd3, 8'h00);
      tick(1);
      check("R8 irq drops when disabled", {7'd0, irq}, 8'h00);
      wr(2'd3, 8'h04);
      tick(1);
      check("R8 irq from level source", {7'd0, irq}, 8'h01);
      wr(2'd2, 8'h44);
      rd(2'd2, v); check("R10 clear reads zero after write", v, 8'h00);
      tick(1);
      check("R8 irq drops after clear", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_level();
      t_edge();
      t_set_wins();
      t_mask();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule